// File: doc/BRIEF.md
# Time-Base Interval Timer

This block runs a free-running binary prescaler counter on the base clock and turns one of its taps into a periodic interval event. A 4-bit select code picks the tap. The block has one 8-bit control/status register on a simple byte bus, made of a select, a write strobe, a read strobe and a qualifier that marks the read half of a read-modify-write access. Each interval event sets a sticky elapsed flag. The flag and an enable bit together drive a level interrupt request. Software can return the counter to zero through a write-only bit in the same register.

Software sets the interval code and the enable bit, then either polls the flag or waits for the interrupt. It acknowledges an event by writing 0 to the flag. Because the flag reads as 1 during the read half of a read-modify-write, a bit-set or bit-clear on another field writes the flag back as 1 and leaves it alone.

Top module: `tbt_timer`

## Requirements
- R1: After reset the counter is 0, all register fields are 0, a read returns 0x00 and `irq` is low.
- R2: The counter advances by one on every clock. A write with bit 0 = 1 returns it to 0 at that edge, and writing bit 0 = 0 has no effect on it. A change of the select code does not disturb the counter.
- R3: Bits 4:1 hold the select code s, which picks tap k = 2*s+1. The flag becomes 1 at the edge after the counter shows bits k..0 equal to 2^k. After a counter clear the flag therefore appears 2^k+1 edges after the clearing edge, and the event repeats every 2^(k+1) edges.
- R4: A write with bit 7 = 0 clears the flag. A write with bit 7 = 1 leaves the flag as it was, whether it is 0 or 1.
- R5: When an interval event and a flag-clearing write fall in the same cycle, the flag ends up 1.
- R6: A read with the read-modify-write qualifier high returns 1 in bit 7, whatever the state of the flag. All other bits read normally.
- R7: `irq` is high exactly while the flag (bit 7) and the enable (bit 6) are both 1.
- R8: Bits 5 and 0 always read 0, and writing 1 to bit 5 changes nothing. Bit 6 and bits 4:1 read back the value last written.
- R9: `reg_rdata` is 0x00 unless `reg_sel` and `reg_rd` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select |
| reg_wr | input | 1 | Write strobe, taken at the clock edge |
| reg_rd | input | 1 | Read strobe, read data is combinational |
| reg_rmw | input | 1 | Marks the read as the first half of a read-modify-write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data |
| irq | output | 1 | Level interrupt request |

## Verification
Two things can land on the flag in the same cycle: the hardware set from an interval event and the software clear from a write with bit 7 = 0. The bench clears the counter and counts edges to the exact cycle in which the counter shows 2^k on the low bits. It then issues the clearing write so that it is sampled at that same edge. The flag must read 1 afterwards. A second clearing write one cycle later, with no event pending, must leave it at 0. This shows that the result comes from the priority and not from a write that was ignored.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  localparam int REG_W   = 8;
  localparam int SEL_W   = 4;

  localparam int POS_FLAG = 7;
  localparam int POS_IE   = 6;
  localparam int POS_RSV  = 5;
  localparam int POS_SELH = 4;
  localparam int POS_SELL = 1;
  localparam int POS_CLR  = 0;

  typedef struct packed {
    logic             flag;
    logic             ie;
    logic [SEL_W-1:0] code;
  } tbt_ctrl_t;

endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  p_clr_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/tbt_tap_detect.sv
module tbt_tap_detect #(
  parameter int CNT_W = 32,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [SEL_W-1:0] code,
  output logic             tick
);

  localparam int NTAP = 1 << SEL_W;

  logic [NTAP-1:0] hit;

  // Counter only increments or returns to 0, so bits k..0 equal to 2^k
  // marks exactly the first cycle after bit k went from 0 to 1.
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int K = 2 * g + 1;
    if (K < CNT_W) begin : g_ok
      assign hit[g] = (cnt[K:0] == {1'b1, {K{1'b0}}});
    end else begin : g_none
      assign hit[g] = 1'b0;
    end
  end

  assign tick = hit[code];

  p_tick_bit_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (cnt != '0));

  initial begin
    a_width_r3: assert (CNT_W >= 2 * NTAP);
  end

endmodule

// File: rtl/tbt_ctrl_reg.sv
module tbt_ctrl_reg
  import tbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             rmw,
  input  logic [REG_W-1:0] wdata,
  input  logic             tick,
  output logic [REG_W-1:0] rdata,
  output logic [SEL_W-1:0] code,
  output logic             cnt_clr,
  output logic             flag,
  output logic             ie
);

  tbt_ctrl_t ctl_q;
  tbt_ctrl_t ctl_d;
  logic      flag_en;
  logic      cfg_en;
  logic      sw_clr;

  assign sw_clr  = wr_en && !wdata[POS_FLAG];
  assign flag_en = tick || sw_clr;
  assign cfg_en  = wr_en;

  always_comb begin
    ctl_d = ctl_q;
    if (flag_en) ctl_d.flag = tick;
    if (cfg_en) begin
      ctl_d.ie   = wdata[POS_IE];
      ctl_d.code = wdata[POS_SELH:POS_SELL];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.flag <= 1'b0;
    end else if (flag_en) begin
      ctl_q.flag <= ctl_d.flag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q.ie   <= 1'b0;
      ctl_q.code <= '0;
    end else if (cfg_en) begin
      ctl_q.ie   <= ctl_d.ie;
      ctl_q.code <= ctl_d.code;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      rdata[POS_FLAG]           = ctl_q.flag | rmw;
      rdata[POS_IE]             = ctl_q.ie;
      rdata[POS_SELH:POS_SELL]  = ctl_q.code;
    end
  end

  assign cnt_clr = wr_en && wdata[POS_CLR];
  assign code    = ctl_q.code;
  assign flag    = ctl_q.flag;
  assign ie      = ctl_q.ie;

  p_flag_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q.flag) |-> $past(wr_en && !wdata[POS_FLAG] && !tick));

  p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.flag && !sw_clr) |=> ctl_q.flag);

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ctl_q.flag);

  p_rmw_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rmw) |-> rdata[POS_FLAG]);

  p_rsv_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[POS_RSV] && !rdata[POS_CLR]);

endmodule

// File: rtl/tbt_timer.sv
module tbt_timer
  import tbt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_sel,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_rmw,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);

  logic [CNT_W-1:0] cnt;
  logic [SEL_W-1:0] code;
  logic             cnt_clr;
  logic             tick;
  logic             flag;
  logic             ie;
  logic             wr_en;
  logic             rd_en;

  assign wr_en = reg_sel && reg_wr;
  assign rd_en = reg_sel && reg_rd;

  tbt_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .cnt   (cnt)
  );

  tbt_tap_detect #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_tap (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (cnt),
    .code  (code),
    .tick  (tick)
  );

  tbt_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rmw     (reg_rmw),
    .wdata   (reg_wdata),
    .tick    (tick),
    .rdata   (reg_rdata),
    .code    (code),
    .cnt_clr (cnt_clr),
    .flag    (flag),
    .ie      (ie)
  );

  assign irq = flag && ie;

  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick || (wr_en && reg_wdata[POS_IE])));

  p_rdata_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (reg_rdata == '0));

endmodule

// File: tb/tbt_timer_tb.sv
`timescale 1ns/1ps
module tbt_timer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_sel = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_rmw = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int m;

  always #2.5 clk = ~clk;

  tbt_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rmw   (reg_rmw),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; sampled at the next posedge; returns at next negedge
  task automatic wr(input logic [7:0] d);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    m++;
  endtask

  task automatic rd(input logic rmw, output logic [7:0] v);
    reg_sel = 1'b1; reg_rd = 1'b1; reg_rmw = rmw;
    #1 v = reg_rdata;
    reg_sel = 1'b0; reg_rd = 1'b0; reg_rmw = 1'b0;
  endtask

  task automatic flag_now(output logic f);
    logic [7:0] v;
    rd(1'b0, v);
    f = v[7];
  endtask

  // clear counter (edge 0) then clear flag (edge 1); m counts edges since clear
  task automatic restart(input int s, input logic en);
    logic [7:0] base;
    base = {1'b0, en, 1'b0, s[3:0], 1'b0};
    m = 0;
    wr(base | 8'h81);
    m = 0;
    wr(base);
  endtask

  task automatic wait_flag(input int limit);
    logic f;
    flag_now(f);
    while (!f && m < limit) begin
      @(negedge clk); m++;
      flag_now(f);
    end
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(1'b0, v);
    check("R1 reset read", v, 8'h00);
    check("R1 reset irq", irq, 0);
    check("R9 idle rdata", reg_rdata, 8'h00);
  endtask

  task automatic t_interval(input int s);
    int k;
    logic f;
    k = 2 * s + 1;
    restart(s, 1'b0);
    flag_now(f);
    check("R4 flag cleared", f, 0);
    wait_flag((1 << k) + 10);
    check($sformatf("R3 first event sel %0d", s), m, (1 << k) + 1);
    wr({3'b000, s[3:0], 1'b0});
    wait_flag(3 * (1 << k) + 10);
    check($sformatf("R3 period sel %0d", s), m, 3 * (1 << k) + 1);
  endtask

  task automatic t_sel_change;
    logic f;
    restart(3, 1'b0);
    while (m < 20) begin @(negedge clk); m++; end
    wr(8'h82);
    flag_now(f);
    check("R2 no flag yet", f, 0);
    wait_flag(200);
    check("R2 select change keeps count", m, 25);
  endtask

  task automatic t_collide;
    logic f;
    restart(1, 1'b0);
    while (m < 8) begin @(negedge clk); m++; end
    wr(8'h02);
    flag_now(f);
    check("R5 set beats clear", f, 1);
    wr(8'h02);
    flag_now(f);
    check("R4 clear without event", f, 0);
  endtask

  task automatic t_irq;
    logic f;
    restart(0, 1'b1);
    check("R7 irq low flag 0", irq, 0);
    wait_flag(20);
    check("R7 irq high", irq, 1);
    wr(8'h80);
    check("R7 irq low ie 0", irq, 0);
    flag_now(f);
    check("R4 write 1 keeps flag", f, 1);
    wr(8'hC0);
    check("R7 irq back", irq, 1);
    wr(8'h40);
    check("R7 irq low after clear", irq, 0);
  endtask

  task automatic t_bits;
    logic [7:0] v;
    restart(7, 1'b0);
    wr(8'h8E);
    rd(1'b0, v);
    check("R4 write 1 on zero flag", v, 8'h0E);
    wr(8'hFF);
    rd(1'b0, v);
    check("R8 reserved and clear bits", v, 8'h5E);
    rd(1'b1, v);
    check("R6 rmw read", v, 8'hDE);
    wr(8'h20);
    rd(1'b0, v);
    check("R8 bit5 write ignored", v, 8'h00);
    check("R9 idle after read", reg_rdata, 8'h00);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_interval(0);
    t_interval(1);
    t_interval(2);
    t_interval(3);
    t_sel_change();
    t_collide();
    t_irq();
    t_bits();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule